// File: doc/BRIEF.md
# In-Memory Carry-Save Multi-Operand Adder

This block models a small storage array that adds its own contents. A host writes up to `MAX_OPS` operands into the first rows of the array and pulses `start` with the operand count. The block then repeats a three-row step. It reads three live rows at once and forms a per-column parity row and a per-column majority row. The majority row is shifted up one bit. Both rows go back into fresh rows of the same array. No data leaves the array between steps, and no carry ripples during a step.

When only two live rows remain, one carry-propagate adder combines them. The block raises `done` and holds the total until the next `start`. Rows carry guard bits above the operand width, so the full sum of `MAX_OPS` maximal operands fits. A count below two or above `MAX_OPS` is refused with an error flag. A count of exactly two goes straight to the final add.

Top module: `csa_pim_adder`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0 and `total` is 0.
- R2: `ld_en` writes `ld_val` into operand row `ld_idx` while the block is idle, zero-extended to the row width. The operand rows are never overwritten by a run, so a second `start` without reloading returns the same total.
- R3: Each reduction step reads three rows. It forms per column a sum bit that is 1 for an odd number of ones, and a carry bit that is 1 when at least two of the three bits are 1.
- R4: Each reduction step takes one compute cycle plus one write-back cycle. `done` rises 2*(n-2)+1 clock edges after the edge that samples an accepted `start` with count n.
- R5: The carry row is shifted left by one position before write-back, and a 0 enters bit 0.
- R6: `total` is `OP_W + clog2(MAX_OPS)` bits wide. It equals the exact sum of the n operands, even when all of them are at their maximum.
- R7: With n = 2 no reduction step runs, and `done` rises one edge after the `start` edge.
- R8: A `start` with n < 2 or n > `MAX_OPS` sets `err`, leaves `busy` low and never raises `done`. The next accepted `start` clears `err`.
- R9: Any `start` clears `done`. Once `done` is set, `done` and `total` stay unchanged until the next `start`.
- R10: `busy` is 1 from the edge after an accepted `start` until the edge that raises `done`. `busy` and `done` are never 1 together.
- R11: `ld_en` while `busy` is 1 has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Operand row write enable |
| ld_idx | input | clog2(MAX_OPS) | Operand row index |
| ld_val | input | OP_W | Operand value |
| start | input | 1 | Start pulse |
| num_ops | input | clog2(MAX_OPS+1) | Number of operand rows to add |
| busy | output | 1 | Reduction or final add in progress |
| done | output | 1 | Total valid and held |
| err | output | 1 | Last start was refused |
| total | output | OP_W+clog2(MAX_OPS) | Sum of the operands |

## Verification
A `start` with count n is sampled on one edge. `busy` and `err` are valid after that same edge. `done` and `total` are due exactly 2*(n-2)+1 edges later. The bench drives and samples on falling edges. It counts falling edges from the start edge until `done` appears, and compares that count with the formula, so a result that is one cycle early or late fails. Hold, rejection and load-while-busy checks each sample at a fixed number of edges after their stimulus.

// File: rtl/pim_pkg.sv
package pim_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_COMP = 2'd1,
        S_WB   = 2'd2,
        S_FIN  = 2'd3
    } seq_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic par3(input logic a, input logic b, input logic c);
        return a ^ b ^ c;
    endfunction

endpackage

// File: rtl/pim_row_array.sv
module pim_row_array #(
    parameter int W    = 11,
    parameter int ROWS = 21,
    parameter int RI_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ext_we,
    input  logic [RI_W-1:0] ext_row,
    input  logic [W-1:0]    ext_data,
    input  logic            wb_we,
    input  logic [RI_W-1:0] wb_a0,
    input  logic [RI_W-1:0] wb_a1,
    input  logic [W-1:0]    wb_d0,
    input  logic [W-1:0]    wb_d1,
    input  logic [RI_W-1:0] rd_a0,
    input  logic [RI_W-1:0] rd_a1,
    input  logic [RI_W-1:0] rd_a2,
    output logic [W-1:0]    rd_q0,
    output logic [W-1:0]    rd_q1,
    output logic [W-1:0]    rd_q2
);

    logic [W-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROWS; i++) cells[i] <= '0;
        end else begin
            if (ext_we) cells[ext_row] <= ext_data;
            if (wb_we) begin
                cells[wb_a0] <= wb_d0;
                cells[wb_a1] <= wb_d1;
            end
        end
    end

    assign rd_q0 = cells[rd_a0];
    assign rd_q1 = cells[rd_a1];
    assign rd_q2 = cells[rd_a2];

    // R11: host writes never collide with write-back
    p_no_dual_write_r11: assert property (@(posedge clk) disable iff (rst)
        !(ext_we && wb_we));

endmodule

// File: rtl/pim_triple_compute.sv
module pim_triple_compute
    import pim_pkg::*;
#(
    parameter int W = 11
) (
    input  logic [W-1:0] row_a,
    input  logic [W-1:0] row_b,
    input  logic [W-1:0] row_c,
    output logic [W-1:0] sum_row,
    output logic [W-1:0] carry_row
);

    logic [W-1:0] maj_col;

    for (genvar i = 0; i < W; i++) begin : g_col
        assign sum_row[i] = par3(row_a[i], row_b[i], row_c[i]);
        assign maj_col[i] = maj3(row_a[i], row_b[i], row_c[i]);
    end

    assign carry_row = {maj_col[W-2:0], 1'b0};

endmodule

// File: rtl/pim_final_add.sv
module pim_final_add
    import pim_pkg::*;
#(
    parameter int W = 11
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] sum
);

    logic [W:0] cy;
    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_rip
        assign sum[i]  = par3(opa[i], opb[i], cy[i]);
        assign cy[i+1] = maj3(opa[i], opb[i], cy[i]);
    end

endmodule

// File: rtl/pim_seq.sv
module pim_seq
    import pim_pkg::*;
#(
    parameter int W       = 11,
    parameter int MAX_OPS = 8,
    parameter int CNT_W   = 4,
    parameter int RI_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] num_ops,
    input  logic [W-1:0]     tri_sum,
    input  logic [W-1:0]     tri_car,
    input  logic [W-1:0]     fin_sum,
    output logic [RI_W-1:0]  rd0,
    output logic [RI_W-1:0]  rd1,
    output logic [RI_W-1:0]  rd2,
    output logic             wb_we,
    output logic [RI_W-1:0]  wb_a0,
    output logic [RI_W-1:0]  wb_a1,
    output logic [W-1:0]     wb_d0,
    output logic [W-1:0]     wb_d1,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [W-1:0]     total
);

    seq_state_e      state;
    logic [RI_W-1:0] rp, wp, live;
    logic [W-1:0]    sum_q, car_q;
    logic            bad_cnt;

    assign live    = wp - rp;
    assign bad_cnt = (num_ops < CNT_W'(2)) || (num_ops > CNT_W'(MAX_OPS));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            rp    <= '0;
            wp    <= '0;
            sum_q <= '0;
            car_q <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
            total <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    done <= 1'b0;
                    if (bad_cnt) begin
                        err <= 1'b1;
                    end else begin
                        err   <= 1'b0;
                        rp    <= '0;
                        wp    <= RI_W'(num_ops);
                        state <= (num_ops == CNT_W'(2)) ? S_FIN : S_COMP;
                    end
                end
                S_COMP: begin
                    sum_q <= tri_sum;
                    car_q <= tri_car;
                    state <= S_WB;
                end
                S_WB: begin
                    rp    <= rp + RI_W'(3);
                    wp    <= wp + RI_W'(2);
                    state <= (live > RI_W'(3)) ? S_COMP : S_FIN;
                end
                S_FIN: begin
                    total <= fin_sum;
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign rd0   = rp;
    assign rd1   = rp + RI_W'(1);
    assign rd2   = rp + RI_W'(2);
    assign wb_we = (state == S_WB);
    assign wb_a0 = wp;
    assign wb_a1 = wp + RI_W'(1);
    assign wb_d0 = sum_q;
    assign wb_d1 = car_q;
    assign busy  = (state != S_IDLE);

    // R4: a write-back cycle always follows exactly one compute cycle
    p_wb_after_comp_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_WB) |-> ($past(state) == S_COMP));
    // R4: at least two live rows whenever work is in flight
    p_live_min_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (live >= RI_W'(2)));
    // R5: the stored carry row has a zero in its lowest bit
    p_carry_lsb_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_WB) |-> (car_q[0] == 1'b0));
    // R8: a refused start leaves the sequencer idle
    p_err_idle_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);
    // R9: result held while no start arrives
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(total)));
    // R10: busy and done are exclusive
    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

endmodule

// File: rtl/csa_pim_adder.sv
module csa_pim_adder #(
    parameter int OP_W    = 8,
    parameter int MAX_OPS = 8,
    localparam int GUARD  = $clog2(MAX_OPS),
    localparam int W      = OP_W + GUARD,
    localparam int ROWS   = 3 * MAX_OPS - 3,
    localparam int RI_W   = $clog2(ROWS),
    localparam int CNT_W  = $clog2(MAX_OPS + 1),
    localparam int OPI_W  = $clog2(MAX_OPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [OPI_W-1:0] ld_idx,
    input  logic [OP_W-1:0]  ld_val,
    input  logic             start,
    input  logic [CNT_W-1:0] num_ops,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [W-1:0]     total
);

    logic [RI_W-1:0] rd0, rd1, rd2, wb_a0, wb_a1;
    logic [W-1:0]    q0, q1, q2, wb_d0, wb_d1, tri_sum, tri_car, fin_sum;
    logic            wb_we, ext_we;

    assign ext_we = ld_en && !busy;

    pim_row_array #(.W(W), .ROWS(ROWS), .RI_W(RI_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .ext_we   (ext_we),
        .ext_row  (RI_W'(ld_idx)),
        .ext_data ({{GUARD{1'b0}}, ld_val}),
        .wb_we    (wb_we),
        .wb_a0    (wb_a0),
        .wb_a1    (wb_a1),
        .wb_d0    (wb_d0),
        .wb_d1    (wb_d1),
        .rd_a0    (rd0),
        .rd_a1    (rd1),
        .rd_a2    (rd2),
        .rd_q0    (q0),
        .rd_q1    (q1),
        .rd_q2    (q2)
    );

    pim_triple_compute #(.W(W)) u_tri (
        .row_a     (q0),
        .row_b     (q1),
        .row_c     (q2),
        .sum_row   (tri_sum),
        .carry_row (tri_car)
    );

    pim_final_add #(.W(W)) u_fin (
        .opa (q0),
        .opb (q1),
        .sum (fin_sum)
    );

    pim_seq #(.W(W), .MAX_OPS(MAX_OPS), .CNT_W(CNT_W), .RI_W(RI_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .num_ops (num_ops),
        .tri_sum (tri_sum),
        .tri_car (tri_car),
        .fin_sum (fin_sum),
        .rd0     (rd0),
        .rd1     (rd1),
        .rd2     (rd2),
        .wb_we   (wb_we),
        .wb_a0   (wb_a0),
        .wb_a1   (wb_a1),
        .wb_d0   (wb_d0),
        .wb_d1   (wb_d1),
        .busy    (busy),
        .done    (done),
        .err     (err),
        .total   (total)
    );

endmodule

// File: tb/csa_pim_adder_tb_top.sv
module csa_pim_adder_tb_top;

    localparam int OP_W = 8;
    localparam int MAX_OPS = 8;
    localparam int W = 11;
    localparam int NV = 6;
    localparam logic [3:0]  V_N   [NV] = '{4'd3, 4'd3, 4'd8, 4'd5, 4'd2, 4'd7};
    localparam logic [63:0] V_OPS [NV] = '{
        64'h0000_0000_00ff_ffff,
        64'h0000_0000_000f_5aa5,
        64'hffff_ffff_ffff_ffff,
        64'h0000_0005_0403_0201,
        64'h0000_0000_0000_8080,
        64'h0013_c7e1_9b6d_37f0
    };

    logic clk = 0, rst = 1, ld_en = 0, start = 0;
    logic [2:0] ld_idx = 0;
    logic [7:0] ld_val = 0;
    logic [3:0] num_ops = 0;
    logic busy, done, err;
    logic [W-1:0] total;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    csa_pim_adder #(.OP_W(OP_W), .MAX_OPS(MAX_OPS)) dut_i (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_val(ld_val),
        .start(start), .num_ops(num_ops), .busy(busy), .done(done),
        .err(err), .total(total)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input int n, input logic [63:0] ops);
        for (int i = 0; i < n; i++) begin
            ld_en = 1; ld_idx = 3'(i); ld_val = ops[i*8 +: 8];
            @(negedge clk);
        end
        ld_en = 0;
    endtask

    task automatic run(input int n, input logic [63:0] ops, input bit spoil, input string tag);
        int exp_sum = 0;
        int lat = 0;
        for (int i = 0; i < n; i++) exp_sum += int'(ops[i*8 +: 8]);
        num_ops = 4'(n); start = 1;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1 && done == 1'b0, "R10 busy after start", busy, 1);
        if (spoil) begin
            ld_en = 1; ld_idx = 3'd7; ld_val = 8'h00;
        end
        while (!done && lat < 100) begin
            @(negedge clk);
            ld_en = 0;
            lat++;
        end
        chk(lat == 2*(n-2)+1, "R4 done latency", lat, 2*(n-2)+1);
        chk(int'(total) == exp_sum, tag, int'(total), exp_sum);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk(!busy && !done && !err && total == 0, "R1 reset state",
            int'({busy, done, err}) + int'(total), 0);

        // table walk: R3, R5, R6, R7 totals
        for (int v = 0; v < NV; v++) begin
            load(int'(V_N[v]), V_OPS[v]);
            run(int'(V_N[v]), V_OPS[v], 1'b0,
                (V_N[v] == 2) ? "R7 two-row total" :
                (V_N[v] == 8) ? "R6 guard-bit total" : "R3 R5 reduction total");
        end

        // R9: hold for several cycles
        held = total;
        repeat (5) @(negedge clk);
        chk(done && total == held, "R9 hold total", int'(total), int'(held));

        // R8: too few operands
        num_ops = 4'd1; start = 1;
        @(negedge clk);
        start = 0;
        chk(err && !busy && !done, "R8 reject n=1", int'({err, busy, done}), 4);
        repeat (4) @(negedge clk);
        chk(!done && !busy, "R8 no done after reject", int'({done, busy}), 0);
        // R8: too many operands
        num_ops = 4'd9; start = 1;
        @(negedge clk);
        start = 0;
        chk(err && !busy, "R8 reject n=9", int'({err, busy}), 2);

        // R11: load during busy ignored; also clears err (R8)
        load(8, 64'hffff_ffff_ffff_ffff);
        num_ops = 4'd8; start = 1;
        @(negedge clk);
        start = 0;
        chk(!err, "R8 err cleared", int'(err), 0);
        ld_en = 1; ld_idx = 3'd7; ld_val = 8'h00;
        @(negedge clk);
        ld_en = 0;
        while (!done) @(negedge clk);
        chk(int'(total) == 2040, "R11 busy load ignored", int'(total), 2040);

        // R2: rerun without reload, operand rows retained
        run(8, 64'hffff_ffff_ffff_ffff, 1'b1, "R2 operands retained");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule